// File: doc/BRIEF.md
# MAC Control Register File

This block is the software-visible register bank of an Ethernet MAC. A 32-bit word bus reaches the mode, interrupt, inter-packet-gap, frame-length, collision, descriptor-count, management and station-address registers. A window in the same address space passes through to an external buffer-descriptor RAM. All registers come out of reset at fixed values. Several writes have side effects: the interrupt status clears when 1s are written to it, the transmit and receive engines get one-cycle start and stop pulses, a reset bit restores the whole bank, and a write to the descriptor count reloads the receive descriptor index.

A built-in responder answers management read commands on behalf of one PHY, whose address is a parameter. The serial management waveform and the frame datapaths are outside the block. The engines raise interrupt events through a set-vector input. They see the receive descriptor index and the station address on dedicated outputs.

Top module: `mac_ctrl_regs`

## Requirements
- R1: Register byte offsets and reset values: mode 0x00 = 0x0000A000, descriptor count 0x04 = 0x40, interrupt status 0x08 = 0, interrupt mask 0x0C = 0, frame length 0x10 = 0x003C0600, gap IPGT 0x14 = 0x12, gap IPGR1 0x18 = 0x0C, gap IPGR2 0x1C = 0x12, collision config 0x20 = 0x000F003F, control mode 0x24 = 0, station low 0x28 = 0, station high 0x2C = 0, hash 0x30/0x34 = 0, management mode 0x38 = 0x64, management command 0x3C, management address 0x40, management write data 0x44, management read data 0x48 and management status 0x4C all = 0. The receive descriptor index resets to 0x80. Plain registers read back what was written.
- R2: A 1 on an irqSet bit sets that interrupt status bit. A write to the status register clears every bit written as 1. If a set and a clear of the same bit happen in one cycle, the set wins.
- R3: intOut is high exactly while some status bit is set whose mask bit (same position) is also set. It drops once a clearing write leaves no unmasked source set.
- R4: Mode bit 1 enables transmit and bit 0 enables receive. A mode write that sets an enable bit that was clear, with reset bit 11 clear, gives a one-cycle start pulse in the cycle after the write. Rewriting an enable bit that is already set gives no pulse.
- R5: A mode write with an enable bit at 0 gives a one-cycle stop pulse for that engine in the cycle after the write.
- R6: A mode write with bit 11 set restores every register and the receive descriptor index to their reset values. The mode then reads 0x0000A000, so the reset bit clears itself. No start pulse is issued.
- R7: A descriptor-count write keeps only bits 7:0 and loads the receive descriptor index with twice that value.
- R8: The station low register holds address bytes 3..0 from bit 31 down. The station high register keeps only bytes 5 and 4, in bits 15:8 and 7:0. stationAddr presents byte 5 in bits 47:40 down to byte 0 in bits 7:0.
- R9: Writes to the management read-data and management status registers leave them unchanged.
- R10: A write of exactly 0x2 to the management command register is a read. It compares the PHY field (address bits 4:0) with the configured PHY address. On a mismatch the read data becomes 0xFFFF.
- R11: For a matching PHY, the register field (address bits 12:8) selects the result: 0 returns 0x0100 (full duplex), 1 returns 0x7824 (link up, autonegotiation done, all four 10/100 abilities), 0x10 returns the PHY address, and any other register returns 0xFFFF. A command value other than 0x2 leaves the read data unchanged.
- R12: Byte offsets 0x400 to 0x7FF map to descriptor RAM word (offset-0x400)/4, for both reads and writes. Other undecoded or unaligned offsets read as zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | Access is a write |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from address |
| irqSet | input | SRC_W | Interrupt events from the engines |
| intOut | output | 1 | Interrupt line |
| txStart | output | 1 | Transmit engine start pulse |
| txStop | output | 1 | Transmit engine stop pulse |
| rxStart | output | 1 | Receive engine start pulse |
| rxStop | output | 1 | Receive engine stop pulse |
| rxBdIndex | output | 9 | Receive descriptor index |
| stationAddr | output | 48 | Station address, byte 5 high |
| bdAddr | output | BD_AW | Descriptor RAM word address |
| bdWe | output | 1 | Descriptor RAM write enable |
| bdWdata | output | 32 | Descriptor RAM write data |
| bdRdata | input | 32 | Descriptor RAM read data |

## Verification
Readback is driven by a seeded random run of writes to the plain registers, interleaved with reads of the whole map. This separates a swapped or mis-decoded offset from a correct one, because every register then carries a distinct value. Directed sequences cover the side effects. Interrupt sets and clears are mixed in the same cycle and with masking, to tell set priority apart from clear priority. Mode writes toggle one enable at a time, to distinguish edge-triggered start from level-triggered start. Management reads step through a mismatched PHY, each modelled register and an unmodelled one. The descriptor window is probed at both ends, and an undecoded hole is checked for side effects.

// File: rtl/macregs_pkg.sv
package macregs_pkg;

  localparam int SRC_W     = 7;
  localparam int REG_COUNT = 20;
  localparam int IDX_W     = $clog2(REG_COUNT);

  // register order defines the byte map: offset = index * 4
  typedef enum logic [IDX_W-1:0] {
    R_MODE, R_TXBD, R_ISRC, R_IMASK, R_PKTLEN, R_IPGT, R_IPGR1, R_IPGR2,
    R_COLL, R_CTRLMODE, R_STA_LO, R_STA_HI, R_HASH0, R_HASH1, R_MIIMODE,
    R_MIICMD, R_MIIADDR, R_MIITX, R_MIIRX, R_MIISTAT
  } regIdx_e;

  localparam int MODE_RXEN = 0;
  localparam int MODE_TXEN = 1;
  localparam int MODE_SRST = 11;

  localparam logic [31:0] MII_CMD_READ = 32'h0000_0002;
  localparam int MII_FIELD_W = 5;
  localparam int MII_PHY_LSB = 0;
  localparam int MII_REG_LSB = 8;

  localparam int TXBD_W  = 8;
  localparam int RXIDX_W = TXBD_W + 1;
  localparam logic [RXIDX_W-1:0] RXIDX_RESET = RXIDX_W'(9'h080);

  typedef struct packed {
    logic [31:0]       mode;
    logic [TXBD_W-1:0] txBdCnt;
    logic [SRC_W-1:0]  intSrc;
    logic [31:0]       intMask;
    logic [31:0]       pktLen;
    logic [31:0]       ipgt;
    logic [31:0]       ipgr1;
    logic [31:0]       ipgr2;
    logic [31:0]       collCfg;
    logic [31:0]       ctrlMode;
    logic [31:0]       staLo;
    logic [15:0]       staHi;
    logic [31:0]       hash0;
    logic [31:0]       hash1;
    logic [31:0]       miiMode;
    logic [31:0]       miiCmd;
    logic [31:0]       miiAddr;
    logic [31:0]       miiTx;
    logic [31:0]       miiRx;
    logic [31:0]       miiStat;
  } regFile_t;

  localparam regFile_t RF_RESET = '{
    mode: 32'h0000_A000, txBdCnt: 8'h40, intSrc: '0, intMask: 32'h0,
    pktLen: 32'h003C_0600, ipgt: 32'h12, ipgr1: 32'h0C, ipgr2: 32'h12,
    collCfg: 32'h000F_003F, ctrlMode: 32'h0, staLo: 32'h0, staHi: 16'h0,
    hash0: 32'h0, hash1: 32'h0, miiMode: 32'h64, miiCmd: 32'h0,
    miiAddr: 32'h0, miiTx: 32'h0, miiRx: 32'h0, miiStat: 32'h0
  };

  typedef struct packed {
    logic [REG_COUNT-1:0] regWr;
    logic                 softRst;
    logic                 miiRead;
  } ctrlStrobes_t;

endpackage

// File: rtl/mii_phy_responder.sv
module mii_phy_responder
  import macregs_pkg::*;
#(
  parameter logic [MII_FIELD_W-1:0] PHY_ADDR   = 5'd1,
  parameter logic [MII_FIELD_W-1:0] PHY_ID_REG = 5'h10
) (
  input  logic [MII_FIELD_W-1:0] phySel,
  input  logic [MII_FIELD_W-1:0] regSel,
  output logic [15:0]            respData
);
  localparam logic [15:0] CTRL_FULL_DUPLEX = 16'h1 << 8;
  localparam logic [15:0] STAT_WORD =
      (16'h1 << 2) | (16'h1 << 5) | (16'h1 << 11) |
      (16'h1 << 12) | (16'h1 << 13) | (16'h1 << 14);

  always_comb begin
    respData = 16'hFFFF;
    if (phySel == PHY_ADDR) begin
      if (regSel == 5'd0)            respData = CTRL_FULL_DUPLEX;
      else if (regSel == 5'd1)       respData = STAT_WORD;
      else if (regSel == PHY_ID_REG) respData = 16'(PHY_ADDR);
    end
  end
endmodule

// File: rtl/macregs_ctrl.sv
module macregs_ctrl
  import macregs_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BD_BASE  = 32'h400,
  parameter int BD_WORDS = 256,
  localparam int BD_AW   = $clog2(BD_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              modeTxEn,
  input  logic              modeRxEn,
  output ctrlStrobes_t      st,
  output regIdx_e           rdIdx,
  output logic              rdReg,
  output logic              rdWin,
  output logic [BD_AW-1:0]  bdAddr,
  output logic              bdWe,
  output logic [31:0]       bdWdata,
  output logic              txStart,
  output logic              txStop,
  output logic              rxStart,
  output logic              rxStop
);
  localparam logic [31:0] REG_SPAN = 32'(REG_COUNT * 4);
  localparam logic [31:0] WIN_LO   = 32'(BD_BASE);
  localparam logic [31:0] WIN_HI   = 32'(BD_BASE + BD_WORDS * 4);

  logic [31:0]          addrExt;
  logic                 regHit, winHit, wrAct;
  logic [REG_COUNT-1:0] regWrVec;
  logic [31:0]          winOff;

  assign addrExt = 32'(busAddr);
  assign regHit  = (addrExt < REG_SPAN) && (busAddr[1:0] == 2'b00);
  assign winHit  = (addrExt >= WIN_LO) && (addrExt < WIN_HI);
  assign wrAct   = busSel & busWe;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_dec
    assign regWrVec[g] = wrAct & regHit & (busAddr[IDX_W+1:2] == IDX_W'(g));
  end

  always_comb begin
    st.regWr   = regWrVec;
    st.softRst = regWrVec[R_MODE] & busWdata[MODE_SRST];
    st.miiRead = regWrVec[R_MIICMD] & (busWdata == MII_CMD_READ);
  end

  assign rdIdx   = regIdx_e'(busAddr[IDX_W+1:2]);
  assign rdReg   = busSel & regHit;
  assign rdWin   = busSel & winHit;
  assign winOff  = addrExt - WIN_LO;
  assign bdAddr  = BD_AW'(winOff >> 2);
  assign bdWe    = wrAct & winHit;
  assign bdWdata = busWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txStart <= 1'b0; txStop <= 1'b0; rxStart <= 1'b0; rxStop <= 1'b0;
    end else begin
      txStart <= regWrVec[R_MODE] & busWdata[MODE_TXEN] & ~modeTxEn & ~busWdata[MODE_SRST];
      rxStart <= regWrVec[R_MODE] & busWdata[MODE_RXEN] & ~modeRxEn & ~busWdata[MODE_SRST];
      txStop  <= regWrVec[R_MODE] & ~busWdata[MODE_TXEN];
      rxStop  <= regWrVec[R_MODE] & ~busWdata[MODE_RXEN];
    end
  end

  // R4: a start pulse only appears once the enable is stored and was clear before
  a_r4_tx_start_edge: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> modeTxEn && !$past(modeTxEn));
  a_r4_rx_start_edge: assert property (@(posedge clk) disable iff (!rstN)
    rxStart |-> modeRxEn && !$past(modeRxEn));
  // R5: a stop pulse leaves the engine disabled
  a_r5_tx_stop_off: assert property (@(posedge clk) disable iff (!rstN)
    txStop |-> !modeTxEn);
  a_r5_rx_stop_off: assert property (@(posedge clk) disable iff (!rstN)
    rxStop |-> !modeRxEn);
endmodule

// File: rtl/macregs_dp.sv
module macregs_dp
  import macregs_pkg::*;
#(
  parameter logic [MII_FIELD_W-1:0] PHY_ADDR   = 5'd1,
  parameter logic [MII_FIELD_W-1:0] PHY_ID_REG = 5'h10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       st,
  input  logic [31:0]        busWdata,
  input  logic [SRC_W-1:0]   irqSet,
  input  regIdx_e            rdIdx,
  input  logic               rdReg,
  input  logic               rdWin,
  input  logic [31:0]        bdRdata,
  output logic [31:0]        busRdata,
  output logic               intOut,
  output logic [RXIDX_W-1:0] rxBdIndex,
  output logic [47:0]        stationAddr,
  output logic               modeTxEn,
  output logic               modeRxEn
);
  regFile_t    rf;
  logic [15:0] phyData;
  logic [31:0] regRd;

  mii_phy_responder #(.PHY_ADDR(PHY_ADDR), .PHY_ID_REG(PHY_ID_REG)) u_phy (
    .phySel  (rf.miiAddr[MII_PHY_LSB +: MII_FIELD_W]),
    .regSel  (rf.miiAddr[MII_REG_LSB +: MII_FIELD_W]),
    .respData(phyData)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rf        <= RF_RESET;
      rxBdIndex <= RXIDX_RESET;
    end else if (st.softRst) begin
      rf        <= RF_RESET;
      rxBdIndex <= RXIDX_RESET;
    end else begin
      rf.intSrc <= (rf.intSrc & ~(st.regWr[R_ISRC] ? busWdata[SRC_W-1:0] : '0)) | irqSet;
      if (st.regWr[R_MODE])     rf.mode     <= busWdata;
      if (st.regWr[R_IMASK])    rf.intMask  <= busWdata;
      if (st.regWr[R_PKTLEN])   rf.pktLen   <= busWdata;
      if (st.regWr[R_IPGT])     rf.ipgt     <= busWdata;
      if (st.regWr[R_IPGR1])    rf.ipgr1    <= busWdata;
      if (st.regWr[R_IPGR2])    rf.ipgr2    <= busWdata;
      if (st.regWr[R_COLL])     rf.collCfg  <= busWdata;
      if (st.regWr[R_CTRLMODE]) rf.ctrlMode <= busWdata;
      if (st.regWr[R_STA_LO])   rf.staLo    <= busWdata;
      if (st.regWr[R_STA_HI])   rf.staHi    <= busWdata[15:0];
      if (st.regWr[R_HASH0])    rf.hash0    <= busWdata;
      if (st.regWr[R_HASH1])    rf.hash1    <= busWdata;
      if (st.regWr[R_MIIMODE])  rf.miiMode  <= busWdata;
      if (st.regWr[R_MIICMD])   rf.miiCmd   <= busWdata;
      if (st.regWr[R_MIIADDR])  rf.miiAddr  <= busWdata;
      if (st.regWr[R_MIITX])    rf.miiTx    <= busWdata;
      if (st.miiRead)           rf.miiRx    <= {16'h0, phyData};
      if (st.regWr[R_TXBD]) begin
        rf.txBdCnt <= busWdata[TXBD_W-1:0];
        rxBdIndex  <= {busWdata[TXBD_W-1:0], 1'b0};
      end
    end
  end

  always_comb begin
    case (rdIdx)
      R_MODE:     regRd = rf.mode;
      R_TXBD:     regRd = 32'(rf.txBdCnt);
      R_ISRC:     regRd = 32'(rf.intSrc);
      R_IMASK:    regRd = rf.intMask;
      R_PKTLEN:   regRd = rf.pktLen;
      R_IPGT:     regRd = rf.ipgt;
      R_IPGR1:    regRd = rf.ipgr1;
      R_IPGR2:    regRd = rf.ipgr2;
      R_COLL:     regRd = rf.collCfg;
      R_CTRLMODE: regRd = rf.ctrlMode;
      R_STA_LO:   regRd = rf.staLo;
      R_STA_HI:   regRd = 32'(rf.staHi);
      R_HASH0:    regRd = rf.hash0;
      R_HASH1:    regRd = rf.hash1;
      R_MIIMODE:  regRd = rf.miiMode;
      R_MIICMD:   regRd = rf.miiCmd;
      R_MIIADDR:  regRd = rf.miiAddr;
      R_MIITX:    regRd = rf.miiTx;
      R_MIIRX:    regRd = rf.miiRx;
      R_MIISTAT:  regRd = rf.miiStat;
      default:    regRd = 32'h0;
    endcase
  end

  assign busRdata    = rdReg ? regRd : (rdWin ? bdRdata : 32'h0);
  assign intOut      = |(rf.intSrc & rf.intMask[SRC_W-1:0]);
  assign stationAddr = {rf.staHi, rf.staLo};
  assign modeTxEn    = rf.mode[MODE_TXEN];
  assign modeRxEn    = rf.mode[MODE_RXEN];

  // R2: bits written as 1 are gone after the write when no event arrives
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    st.regWr[R_ISRC] && (irqSet == '0) |=> (rf.intSrc & $past(busWdata[SRC_W-1:0])) == '0);
  // R3: a write that clears every pending source drops the interrupt line
  a_r3_int_drops: assert property (@(posedge clk) disable iff (!rstN)
    st.regWr[R_ISRC] && (irqSet == '0) && ((rf.intSrc & ~busWdata[SRC_W-1:0]) == '0) |=> !intOut);
  // R6: soft reset restores mode and the descriptor index
  a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    st.softRst |=> (rf.mode == RF_RESET.mode) && (rxBdIndex == RXIDX_RESET));
  // R7: descriptor index follows twice the written count
  a_r7_index_reload: assert property (@(posedge clk) disable iff (!rstN)
    st.regWr[R_TXBD] |=> rxBdIndex == {$past(busWdata[TXBD_W-1:0]), 1'b0});
  // R10: a read to a foreign PHY returns all ones
  a_r10_phy_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    st.miiRead && (rf.miiAddr[MII_PHY_LSB +: MII_FIELD_W] != PHY_ADDR) |=> rf.miiRx[15:0] == 16'hFFFF);
  // R9: read-only management status never moves
  a_r9_status_stable: assert property (@(posedge clk) disable iff (!rstN)
    st.regWr[R_MIISTAT] |=> $stable(rf.miiStat) || $past(st.softRst));
endmodule

// File: rtl/mac_ctrl_regs.sv
module mac_ctrl_regs
  import macregs_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int BD_BASE  = 32'h400,
  parameter int BD_WORDS = 256,
  parameter logic [4:0] PHY_ADDR   = 5'd1,
  parameter logic [4:0] PHY_ID_REG = 5'h10,
  localparam int BD_AW = $clog2(BD_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [SRC_W-1:0]    irqSet,
  output logic                intOut,
  output logic                txStart,
  output logic                txStop,
  output logic                rxStart,
  output logic                rxStop,
  output logic [RXIDX_W-1:0]  rxBdIndex,
  output logic [47:0]         stationAddr,
  output logic [BD_AW-1:0]    bdAddr,
  output logic                bdWe,
  output logic [31:0]         bdWdata,
  input  logic [31:0]         bdRdata
);
  ctrlStrobes_t st;
  regIdx_e      rdIdx;
  logic         rdReg, rdWin, modeTxEn, modeRxEn;

  macregs_ctrl #(.ADDR_W(ADDR_W), .BD_BASE(BD_BASE), .BD_WORDS(BD_WORDS)) u_ctrl (
    .clk, .rstN, .busSel, .busWe, .busAddr, .busWdata, .modeTxEn, .modeRxEn,
    .st, .rdIdx, .rdReg, .rdWin, .bdAddr, .bdWe, .bdWdata,
    .txStart, .txStop, .rxStart, .rxStop
  );

  macregs_dp #(.PHY_ADDR(PHY_ADDR), .PHY_ID_REG(PHY_ID_REG)) u_dp (
    .clk, .rstN, .st, .busWdata, .irqSet, .rdIdx, .rdReg, .rdWin, .bdRdata,
    .busRdata, .intOut, .rxBdIndex, .stationAddr, .modeTxEn, .modeRxEn
  );
endmodule

// File: tb/mac_ctrl_regs_bench.sv
module mac_ctrl_regs_bench;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        busSel = 0, busWe = 0;
  logic [10:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [6:0]  irqSet = '0;
  logic        intOut, txStart, txStop, rxStart, rxStop, bdWe;
  logic [8:0]  rxBdIndex;
  logic [47:0] stationAddr;
  logic [7:0]  bdAddr;
  logic [31:0] bdWdata, bdRdata;
  logic [31:0] bdMem [0:255];
  logic [31:0] model [0:19];
  int checks = 0, errors = 0;
  bit done = 0;
  logic pTxS, pTxP, pRxS, pRxP;
  logic [31:0] rv;

  always #10 clk = ~clk;

  mac_ctrl_regs u_mac_ctrl_regs (.*);

  assign bdRdata = bdMem[bdAddr];
  always @(posedge clk) if (bdWe) bdMem[bdAddr] <= bdWdata;

  function automatic logic [31:0] defVal(int i);
    case (i)
      0: return 32'h0000A000;  1: return 32'h40;  4: return 32'h003C0600;
      5: return 32'h12;  6: return 32'h0C;  7: return 32'h12;
      8: return 32'h000F003F;  14: return 32'h64;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int plainIdx(int k);
    case (k)
      0: return 3; 1: return 4; 2: return 5; 3: return 6; 4: return 7; 5: return 8;
      6: return 9; 7: return 12; 8: return 13; 9: return 14; 10: return 16; default: return 17;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    pTxS = txStart; pTxP = txStop; pRxS = rxStart; pRxP = rxStop;
    busSel = 0; busWe = 0;
  endtask

  task automatic rd(logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic raise(logic [6:0] b);
    @(negedge clk); irqSet = b;
    @(negedge clk); irqSet = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) bdMem[i] = 32'h0;
    for (int i = 0; i < 20; i++) model[i] = defVal(i);
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset values
    for (int i = 0; i < 20; i++) begin
      rd(11'(i * 4), rv);
      chk("R1 reset value", 64'(rv), 64'(defVal(i)));
    end
    chk("R1 rx index reset", 64'(rxBdIndex), 64'h80);
    chk("R3 int low at reset", 64'(intOut), 64'h0);

    // R1 random readback of plain registers
    for (int n = 0; n < 150; n++) begin
      int k = plainIdx(int'($urandom % 12));
      logic [31:0] d = $urandom;
      int r = int'($urandom % 20);
      wr(11'(k * 4), d);
      model[k] = d;
      rd(11'(r * 4), rv);
      chk("R1 random readback", 64'(rv), 64'(model[r]));
    end

    // R2 / R3 interrupts
    wr(11'h0C, 32'h7F);
    raise(7'h55);
    rd(11'h08, rv); chk("R2 set by event", 64'(rv), 64'h55);
    chk("R3 int high", 64'(intOut), 64'h1);
    wr(11'h08, 32'h05);
    rd(11'h08, rv); chk("R2 w1c partial", 64'(rv), 64'h50);
    chk("R3 int still high", 64'(intOut), 64'h1);
    wr(11'h08, 32'h50);
    chk("R3 int drops", 64'(intOut), 64'h0);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = 11'h08; busWdata = 32'h1; irqSet = 7'h1;
    @(negedge clk);
    busSel = 0; busWe = 0; irqSet = '0;
    rd(11'h08, rv); chk("R2 set wins over clear", 64'(rv), 64'h1);
    wr(11'h0C, 32'h0);
    chk("R3 masked source", 64'(intOut), 64'h0);
    wr(11'h08, 32'h7F);

    // R4 / R5 mode pulses
    wr(11'h00, 32'h0000A002);
    chk("R4 tx start", 64'({pTxS, pTxP, pRxS, pRxP}), 64'b1001);
    wr(11'h00, 32'h0000A002);
    chk("R4 no repeat start", 64'({pTxS, pTxP, pRxS, pRxP}), 64'b0001);
    wr(11'h00, 32'h0000A003);
    chk("R4 rx start", 64'({pTxS, pTxP, pRxS, pRxP}), 64'b0010);
    wr(11'h00, 32'h0000A000);
    chk("R5 both stop", 64'({pTxS, pTxP, pRxS, pRxP}), 64'b0101);

    // R6 soft reset
    wr(11'h14, 32'h99);
    wr(11'h04, 32'h5);
    wr(11'h00, 32'h00000802);
    chk("R6 no start on reset", 64'(pTxS), 64'h0);
    rd(11'h00, rv); chk("R6 mode self clears", 64'(rv), 64'h0000A000);
    rd(11'h14, rv); chk("R6 gap restored", 64'(rv), 64'h12);
    chk("R6 rx index restored", 64'(rxBdIndex), 64'h80);

    // R7 descriptor count
    wr(11'h04, 32'h1234);
    rd(11'h04, rv); chk("R7 low byte kept", 64'(rv), 64'h34);
    chk("R7 index reload", 64'(rxBdIndex), 64'h68);
    wr(11'h04, 32'hFF);
    chk("R7 index max", 64'(rxBdIndex), 64'h1FE);

    // R8 station address
    wr(11'h28, 32'h44332211);
    wr(11'h2C, 32'hABCD6655);
    rd(11'h2C, rv); chk("R8 high half", 64'(rv), 64'h6655);
    chk("R8 station output", 64'(stationAddr), 64'h665544332211);

    // R10 / R11 management reads
    wr(11'h40, 32'h00000003);
    wr(11'h3C, 32'h2);
    rd(11'h48, rv); chk("R10 phy mismatch", 64'(rv), 64'hFFFF);
    wr(11'h40, 32'h00000001);
    wr(11'h3C, 32'h2);
    rd(11'h48, rv); chk("R11 control reg", 64'(rv), 64'h0100);
    wr(11'h40, 32'h00000101);
    wr(11'h3C, 32'h2);
    rd(11'h48, rv); chk("R11 status reg", 64'(rv), 64'h7824);
    wr(11'h40, 32'h00001001);
    wr(11'h3C, 32'h2);
    rd(11'h48, rv); chk("R11 phy address reg", 64'(rv), 64'h1);
    wr(11'h40, 32'h00000501);
    wr(11'h3C, 32'h4);
    rd(11'h48, rv); chk("R11 other command no read", 64'(rv), 64'h1);
    wr(11'h3C, 32'h2);
    rd(11'h48, rv); chk("R11 unmodelled reg", 64'(rv), 64'hFFFF);

    // R9 read-only
    wr(11'h48, 32'hDEAD);
    rd(11'h48, rv); chk("R9 rx data read-only", 64'(rv), 64'hFFFF);
    wr(11'h4C, 32'hBEEF);
    rd(11'h4C, rv); chk("R9 status read-only", 64'(rv), 64'h0);

    // R12 descriptor window and holes
    wr(11'h400, 32'hCAFE0001);
    wr(11'h7FC, 32'hCAFE00FF);
    rd(11'h400, rv); chk("R12 window first", 64'(rv), 64'hCAFE0001);
    rd(11'h7FC, rv); chk("R12 window last", 64'(rv), 64'hCAFE00FF);
    chk("R12 ram word 255", 64'(bdMem[255]), 64'hCAFE00FF);
    wr(11'h060, 32'hFFFFFFFF);
    rd(11'h060, rv); chk("R12 hole reads zero", 64'(rv), 64'h0);
    wr(11'h015, 32'hFFFFFFFF);
    rd(11'h014, rv); chk("R12 unaligned ignored", 64'(rv), 64'h12);
    rd(11'h3FC, rv); chk("R12 gap below window", 64'(rv), 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule